// File: doc/BRIEF.md
# I2S Transmit Sample Formatter and Serializer

This block takes 32-bit words from a write-only port into an eight-entry FIFO. At each frame boundary it unpacks the head word into a left and a right sample, using the selected sample width and mono/stereo setting. It then shifts both samples out MSB first on a serial data line, with a word-select line that marks the channel. Each bit advances only on a cycle where the bit-clock enable input is high, so the bit rate is set by whatever logic drives that enable.

The mode fields come from a control word held outside the block. They are a 2-bit width code, a mono flag, a stop flag, a channel-clear flag and a mute flag. Software-side logic sees only the full flag, the FIFO level and a sticky overflow flag.

The packing in the FIFO depends on the mode. For 8-bit and 16-bit stereo, one FIFO word holds the whole pair. For 32-bit stereo, the pair takes two consecutive words, left first. In mono modes, each word holds one sample, and that sample is played in both slots.

Top module: `i2s_tx_fmt`

## Requirements
- R1: `width_i` selects the slot length. Code 00 gives 8 bits, 01 gives 16 bits and 11 gives 32 bits. The reserved code 10 behaves exactly like 01.
- R2: In 8-bit stereo, the left sample is word bits [7:0] and the right sample is bits [15:8]. In 16-bit stereo, left is bits [15:0] and right is bits [31:16]. Each such pair is one FIFO word.
- R3: In 32-bit stereo, left is the first FIFO word and right is the next one. A frame plays data only if at least two words are present at frame start; otherwise it plays zeros and pops nothing.
- R4: With `mono_i`=1, each word carries one sample, taken from the low 8, low 16 or all 32 bits. That sample is sent in both the left and the right slot.
- R5: Serial data is sent MSB first. `ws_o` is 0 for the left slot and 1 for the right slot. Before every bit tick, `ws_o` shows the channel of the bit that the tick will put on `sd_o`, so it changes one bit before each MSB.
- R6: If the FIFO holds no usable sample at frame start, that frame sends all zeros, word-select still alternates, and the FIFO is not popped.
- R7: While `mute_i`=1, `sd_o` is 0 on every tick. Word-select keeps running and samples are still consumed.
- R8: The FIFO holds 8 words in write order. `level_o` gives the count, and `full_o` is 1 exactly when the count is 8.
- R9: A write while `full_o`=1 is dropped and sets `ovf_o`. `ovf_o` stays set until a channel clear or `rst_ni`.
- R10: While `stop_i`=1, the serializer rests at frame start with `sd_o`=0 and `ws_o`=0, and it pops nothing. FIFO writes are still accepted.
- R11: While `clr_i`=1, the FIFO is emptied, `ovf_o` is cleared, the serializer returns to frame start, and writes are ignored.
- R12: `sd_o` and `ws_o` change only on cycles with `bclk_en_i`=1 (besides stop, clear and reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | FIFO write strobe |
| wr_data_i | input | 32 | FIFO write word |
| full_o | output | 1 | FIFO holds 8 words |
| level_o | output | 4 | Number of words in the FIFO |
| ovf_o | output | 1 | Sticky dropped-write flag |
| width_i | input | 2 | Sample width code |
| mono_i | input | 1 | 1 = mono, 0 = stereo |
| stop_i | input | 1 | Hold serializer idle |
| clr_i | input | 1 | Clear FIFO, flag and serializer |
| mute_i | input | 1 | Force zero serial data |
| bclk_en_i | input | 1 | One-cycle bit-clock enable |
| sd_o | output | 1 | Serial data |
| ws_o | output | 1 | Word select |

## Verification
The assertions take the following for granted about the inputs. `bclk_en_i` is a single-cycle strobe. `width_i` and `mono_i` are stable whenever they are sampled, which is at frame start. Pops only ever come from the serializer. The stimulus changes mode fields only while `clr_i` or `stop_i` holds the serializer at frame start. It drives all inputs on the falling edge and ticks the bit enable on consecutive cycles, so every frame begins aligned to a clear and the bench can check each bit position directly.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CNT_W  = IDX_W + 1;

  typedef enum logic [1:0] {
    WID_8   = 2'b00,
    WID_16  = 2'b01,
    WID_RSV = 2'b10,
    WID_32  = 2'b11
  } width_e;

  // reserved code falls back to 16
  function automatic logic [CNT_W-1:0] slot_bits(input logic [1:0] code);
    case (code)
      WID_8:   slot_bits = CNT_W'(WORD_W / 4);
      WID_32:  slot_bits = CNT_W'(WORD_W);
      default: slot_bits = CNT_W'(WORD_W / 2);
    endcase
  endfunction
endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rd_ptr_q, wr_ptr_q;
  logic [LW-1:0] cnt_q;
  logic          push, pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    ptr_inc = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign head_o  = mem_q[rd_ptr_q];
  assign push    = wr_i && !full_o && !clr_i;
  assign pop     = pop_i && !empty_o && !clr_i;

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else if (clr_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + LW'(push) - LW'(pop);
      if (wr_i && full_o) ovf_o <= 1'b1;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH)); // R8
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_i |=> ovf_o); // R9
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i && !pop_i && !clr_i |=> full_o && ovf_o); // R9
  AST_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o && !ovf_o); // R11
endmodule

// File: rtl/i2s_tx_unpack.sv
module i2s_tx_unpack
  import i2s_tx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        width_i,
  input  logic              mono_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              two_words_o
);
  localparam int QW = WORD_W / 4;
  localparam int HW = WORD_W / 2;

  always_comb begin
    two_words_o = 1'b0;
    case (width_i)
      WID_8: begin
        left_o  = {{(WORD_W-QW){1'b0}}, word_i[QW-1:0]};
        right_o = mono_i ? left_o : {{(WORD_W-QW){1'b0}}, word_i[2*QW-1:QW]};
      end
      WID_32: begin
        left_o      = word_i;
        right_o     = mono_i ? word_i : '0; // stereo right arrives in the next word
        two_words_o = !mono_i;
      end
      default: begin
        left_o  = {{(WORD_W-HW){1'b0}}, word_i[HW-1:0]};
        right_o = mono_i ? left_o : {{(WORD_W-HW){1'b0}}, word_i[WORD_W-1:HW]};
      end
    endcase
  end
endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
  import i2s_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              stop_i,
  input  logic              mute_i,
  input  logic              tick_i,
  input  logic [1:0]        width_i,
  input  logic              mono_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic              empty_i,
  input  logic              have2_i,
  output logic              pop_o,
  output logic              sd_o,
  output logic              ws_o
);
  logic              ch_q, live_q, mono_q;
  logic [IDX_W-1:0]  k_q;
  logic [1:0]        wcode_q;
  logic [WORD_W-1:0] left_q, right_q;

  logic              frame_start, right32_start, avail, two_words, last, cur_bit;
  logic [1:0]        wcode;
  logic [CNT_W-1:0]  nbits;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] u_left, u_right, slot_val;

  i2s_tx_unpack u_unpack (
    .word_i      (head_i),
    .width_i     (width_i),
    .mono_i      (mono_i),
    .left_o      (u_left),
    .right_o     (u_right),
    .two_words_o (two_words)
  );

  always_comb begin
    frame_start   = !ch_q && (k_q == '0);
    right32_start = ch_q && (k_q == '0) && live_q && (wcode_q == WID_32) && !mono_q;
    avail         = two_words ? have2_i : !empty_i;
    wcode         = frame_start ? width_i : wcode_q;
    nbits         = slot_bits(wcode);
    idx           = IDX_W'(nbits - CNT_W'(1) - {1'b0, k_q});
    last          = (k_q == IDX_W'(nbits - CNT_W'(1)));
    if (frame_start)        slot_val = avail ? u_left : '0;
    else if (right32_start) slot_val = head_i;
    else if (ch_q)          slot_val = right_q;
    else                    slot_val = left_q;
    cur_bit = slot_val[idx];
    pop_o   = tick_i && !stop_i && !clr_i && ((frame_start && avail) || right32_start);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q    <= 1'b0;
      k_q     <= '0;
      live_q  <= 1'b0;
      mono_q  <= 1'b0;
      wcode_q <= WID_16;
      left_q  <= '0;
      right_q <= '0;
      sd_o    <= 1'b0;
      ws_o    <= 1'b0;
    end else if (clr_i || stop_i) begin
      ch_q   <= 1'b0;
      k_q    <= '0;
      live_q <= 1'b0;
      sd_o   <= 1'b0;
      ws_o   <= 1'b0;
    end else if (tick_i) begin
      if (frame_start) begin
        wcode_q <= width_i;
        mono_q  <= mono_i;
        live_q  <= avail;
        left_q  <= avail ? u_left : '0;
        right_q <= avail ? u_right : '0;
      end
      if (right32_start) right_q <= head_i;
      sd_o <= cur_bit && !mute_i;
      // ws reflects the channel of the bit the next tick drives
      if (last) begin
        k_q  <= '0;
        ch_q <= !ch_q;
        ws_o <= !ch_q;
      end else begin
        k_q  <= k_q + IDX_W'(1);
        ws_o <= ch_q;
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !stop_i && !clr_i |=> $stable(sd_o) && $stable(ws_o)); // R12
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sd_o && !ws_o); // R10
  AST_MUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && mute_i |=> !sd_o); // R7
  AST_NO_POP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !pop_o); // R12
endmodule

// File: rtl/i2s_tx_fmt.sv
module i2s_tx_fmt #(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [31:0]   wr_data_i,
  output logic          full_o,
  output logic [LW-1:0] level_o,
  output logic          ovf_o,
  input  logic [1:0]    width_i,
  input  logic          mono_i,
  input  logic          stop_i,
  input  logic          clr_i,
  input  logic          mute_i,
  input  logic          bclk_en_i,
  output logic          sd_o,
  output logic          ws_o
);
  import i2s_tx_pkg::*;

  logic [WORD_W-1:0] head;
  logic              pop, empty, have2;

  assign have2 = (level_o >= LW'(2));

  i2s_tx_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .wr_i    (wr_en_i),
    .wdata_i (wr_data_i),
    .pop_i   (pop),
    .head_o  (head),
    .level_o (level_o),
    .full_o  (full_o),
    .empty_o (empty),
    .ovf_o   (ovf_o)
  );

  i2s_tx_ser u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .stop_i  (stop_i),
    .mute_i  (mute_i),
    .tick_i  (bclk_en_i),
    .width_i (width_i),
    .mono_i  (mono_i),
    .head_i  (head),
    .empty_i (empty),
    .have2_i (have2),
    .pop_o   (pop),
    .sd_o    (sd_o),
    .ws_o    (ws_o)
  );
endmodule

// File: tb/i2s_tx_fmt_tb.sv
`timescale 1ns/1ps
module i2s_tx_fmt_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        full, ovf, sd, ws;
  logic [3:0]  level;
  logic [1:0]  width = 2'b01;
  logic        mono = 1'b0, stop = 1'b0, clr = 1'b0, mute = 1'b0, bclk_en = 1'b0;
  int          nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  i2s_tx_fmt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .full_o(full), .level_o(level), .ovf_o(ovf), .width_i(width), .mono_i(mono),
    .stop_i(stop), .clr_i(clr), .mute_i(mute), .bclk_en_i(bclk_en),
    .sd_o(sd), .ws_o(ws)
  );

  typedef struct packed {
    logic [1:0]  wc;
    logic        mono;
    logic [31:0] w0, w1, el, er;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b01, 1'b0, 32'h1234ABCD, 32'h0, 32'h0000ABCD, 32'h00001234}, // R2 16 stereo
    '{2'b00, 1'b0, 32'hFFFFC35A, 32'h0, 32'h0000005A, 32'h000000C3}, // R2 8 stereo
    '{2'b11, 1'b0, 32'h80000001, 32'h7FFFFFFE, 32'h80000001, 32'h7FFFFFFE}, // R3
    '{2'b01, 1'b1, 32'hFFFF8001, 32'h0, 32'h00008001, 32'h00008001}, // R4
    '{2'b00, 1'b1, 32'h123456A5, 32'h0, 32'h000000A5, 32'h000000A5}, // R4
    '{2'b11, 1'b1, 32'hDEADBEEF, 32'h0, 32'hDEADBEEF, 32'hDEADBEEF}, // R4
    '{2'b10, 1'b0, 32'h55AA33CC, 32'h0, 32'h000033CC, 32'h000055AA}  // R1 reserved
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk) begin wr_en = 1'b1; wr_data = w; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  // caller sits at a negedge; ws is sampled before the tick, sd after it
  task automatic tick_once(output logic s, output logic wsb);
    wsb = ws;
    bclk_en = 1'b1;
    @(negedge clk) bclk_en = 1'b0;
    s = sd;
  endtask

  task automatic run_frame(input int nb, input logic [31:0] el, input logic [31:0] er,
                           input string req);
    logic [31:0] gl, gr;
    logic        s, wsb, ws_bad;
    gl = '0; gr = '0; ws_bad = 1'b0;
    for (int i = 0; i < 2 * nb; i++) begin
      tick_once(s, wsb);
      if (wsb !== (i >= nb)) ws_bad = 1'b1; // R5 lead rule
      if (i < nb) gl = {gl[30:0], s};
      else        gr = {gr[30:0], s};
    end
    chk({req, " left"}, gl, el);
    chk({req, " right"}, gr, er);
    chk({req, " R5 ws"}, {31'b0, ws_bad}, 32'h0);
  endtask

  function automatic int nbits_of(input logic [1:0] c);
    return (c == 2'b00) ? 8 : (c == 2'b11) ? 32 : 16;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R12 watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin : main
    logic s, wsb, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset level", {28'b0, level}, 32'd0);
    chk("R8 reset full", {31'b0, full}, 32'd0);
    chk("R9 reset ovf", {31'b0, ovf}, 32'd0);
    chk("R5 reset ws/sd", {30'b0, ws, sd}, 32'd0);

    // table walk
    for (int v = 0; v < 7; v++) begin
      width = VECS[v].wc; mono = VECS[v].mono;
      do_clr();
      wr(VECS[v].w0);
      if (VECS[v].wc == 2'b11 && !VECS[v].mono) wr(VECS[v].w1);
      run_frame(nbits_of(VECS[v].wc), VECS[v].el, VECS[v].er, $sformatf("R1 vec%0d", v));
      chk("R8 vec drained", {28'b0, level}, 32'd0);
    end

    // R6 empty FIFO
    width = 2'b01; mono = 1'b0;
    do_clr();
    run_frame(16, 32'h0, 32'h0, "R6 empty");
    chk("R6 no pop", {28'b0, level}, 32'd0);

    // R3 single word in 32-bit stereo
    width = 2'b11;
    do_clr();
    wr(32'hCAFEF00D);
    run_frame(32, 32'h0, 32'h0, "R3 lone word");
    chk("R3 kept word", {28'b0, level}, 32'd1);
    wr(32'h0BADBEEF);
    run_frame(32, 32'hCAFEF00D, 32'h0BADBEEF, "R3 pair");

    // R7 mute
    width = 2'b01;
    do_clr();
    wr(32'hFFFFFFFF);
    mute = 1'b1;
    run_frame(16, 32'h0, 32'h0, "R7 mute");
    chk("R7 consumed", {28'b0, level}, 32'd0);
    mute = 1'b0;

    // R12 no ticks: outputs idle, nothing popped
    do_clr();
    wr(32'h00010002);
    repeat (5) @(negedge clk);
    chk("R12 idle outputs", {30'b0, ws, sd}, 32'd0);
    chk("R12 idle level", {28'b0, level}, 32'd1);

    // R10 stop holds serializer, writes still land
    stop = 1'b1;
    bad = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick_once(s, wsb);
      if (s !== 1'b0 || ws !== 1'b0) bad = 1'b1;
    end
    chk("R10 stopped outputs", {31'b0, bad}, 32'd0);
    wr(32'h00030004);
    chk("R10 write during stop", {28'b0, level}, 32'd2);
    stop = 1'b0;
    run_frame(16, 32'h0002, 32'h0001, "R10 resume");
    run_frame(16, 32'h0004, 32'h0003, "R8 back-to-back");

    // R8/R9 fill, overflow, order
    do_clr();
    for (int i = 0; i < 9; i++) wr({16'(i + 16'h100), 16'(i)});
    chk("R8 full level", {28'b0, level}, 32'd8);
    chk("R8 full flag", {31'b0, full}, 32'd1);
    chk("R9 ovf set", {31'b0, ovf}, 32'd1);
    for (int i = 0; i < 8; i++)
      run_frame(16, 32'(i), 32'(i + 'h100), $sformatf("R8 order%0d", i));
    run_frame(16, 32'h0, 32'h0, "R9 dropped word");
    chk("R9 ovf sticky", {31'b0, ovf}, 32'd1);

    // R11 clear
    wr(32'h11112222);
    do_clr();
    chk("R11 clr level", {28'b0, level}, 32'd0);
    chk("R11 clr ovf", {31'b0, ovf}, 32'd0);
    @(negedge clk) begin clr = 1'b1; wr_en = 1'b1; wr_data = 32'h3; end
    @(negedge clk) begin clr = 1'b0; wr_en = 1'b0; end
    chk("R11 write ignored", {28'b0, level}, 32'd0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule